// File: doc/BRIEF.md
# Self-Correcting Redundant Counter

This block is an up-counter meant for logic that must keep a correct count when a particle strike flips a stored bit. The count can be held in three identical register copies. A bitwise two-of-three majority vote combines them into one value, and that vote is what the outside world sees. A corrupted copy is outvoted, so it never reaches the output.

Three parameters are chosen per instance. The first picks the overflow rule: roll over to zero, or stick at the all-ones value. The second picks the voter style. With one voter, each copy steps from its own stored value, so a damaged copy stays damaged until the next clear or reset. With three voters, each copy has its own vote and is reloaded from it on every clock, so a single bad copy is repaired at the next edge. The third parameter removes the redundancy entirely and leaves one ordinary register. A registered flag reports, one cycle late, any edge at which the copies did not all hold the same value.

Top module: `tmr_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every copy is loaded with zero. After that edge `count_o` is 0 and `mismatch_o` is 0.
- R2: At an edge where `clr_i` is low and `inc_i` is high, `count_o` rises by exactly one, except at the limit covered by R4 and R5. At an edge where both inputs are low, `count_o` keeps its value.
- R3: At an edge where `clr_i` is high, `count_o` becomes 0 whatever the value of `inc_i`.
- R4: In roll-over mode, an increment at the all-ones value gives 0.
- R5: In sticking mode, an increment at the all-ones value leaves `count_o` at all ones. This holds with or without redundancy.
- R6: `count_o` is the bitwise majority of the three copies. A single corrupted copy does not change `count_o` in any voter style.
- R7: With three voters, each copy is reloaded from the vote at every edge. A single corrupted copy therefore agrees with the others again after the next edge, and `mismatch_o` is high for exactly one cycle.
- R8: With one voter, each copy steps from its own stored value. A corrupted copy keeps disagreeing, and `mismatch_o` stays high, until a clear or reset edge. `mismatch_o` then falls one cycle later.
- R9: If the copies disagree at an edge, `mismatch_o` is high after that edge. If they agree at an edge, `mismatch_o` is low after that edge.
- R10: With redundancy removed, there is a single register, it counts as in R2 to R5, and `mismatch_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_i | input | 1 | Increment enable |
| clr_i | input | 1 | Clear to zero; takes priority over increment |
| count_o | output | WIDTH | Voted count value |
| mismatch_o | output | 1 | Registered flag: the copies disagreed at the previous edge |

## Verification
The assertions check the following on every cycle:
- the step-by-one and hold rules;
- that a clear wins over an increment;
- the roll-over or sticking behaviour at all ones;
- that `mismatch_o` follows whether the copies agreed at the previous edge;
- that, with three voters, a raised flag always comes with copies that agree again.

Only the bench scenarios can show that the output stays correct while one copy is corrupted. To do this, the bench forces a wrong value into a single copy between clock edges. The same scenarios show that a corrupted copy persists with one voter and is gone after one edge with three voters. They also show that a clear or a reset mid-run removes a lasting disagreement.

// File: rtl/tmr_counter_pkg.sv
package tmr_counter_pkg;

  typedef enum logic {
    CNT_WRAP = 1'b0,
    CNT_SAT  = 1'b1
  } cnt_mode_e;

  typedef enum logic {
    VOTE_SINGLE = 1'b0,
    VOTE_TRIPLE = 1'b1
  } voter_e;

endpackage

// File: rtl/tmr_counter_vote.sv
module tmr_counter_vote #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] y_o
);

  // Bitwise two-of-three majority.
  assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);

endmodule

// File: rtl/tmr_counter_lane.sv
module tmr_counter_lane #(
  parameter int                         WIDTH = 8,
  parameter tmr_counter_pkg::cnt_mode_e MODE  = tmr_counter_pkg::CNT_WRAP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [WIDTH-1:0] base_i,
  output logic [WIDTH-1:0] q_o
);

  localparam logic [WIDTH-1:0] MAXV = '1;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] stepped;
  logic [WIDTH-1:0] nxt;

  // The overflow rule is fixed per instance.
  generate
    if (MODE == tmr_counter_pkg::CNT_SAT) begin : g_sat
      assign stepped = (base_i == MAXV) ? base_i : base_i + 1'b1;
    end else begin : g_wrap
      assign stepped = base_i + 1'b1;
    end
  endgenerate

  // Clear wins over increment.
  always_comb begin
    if (clr_i)      nxt = '0;
    else if (inc_i) nxt = stepped;
    else            nxt = base_i;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign q_o = q;

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int                         WIDTH   = 8,
  parameter tmr_counter_pkg::cnt_mode_e MODE    = tmr_counter_pkg::CNT_WRAP,
  parameter tmr_counter_pkg::voter_e    VOTER   = tmr_counter_pkg::VOTE_TRIPLE,
  parameter bit                         USE_TMR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] count_o,
  output logic             mismatch_o
);

  localparam int               NL   = USE_TMR ? 3 : 1;
  localparam logic [WIDTH-1:0] MAXV = '1;

  logic [WIDTH-1:0] lane_q    [NL];
  logic [WIDTH-1:0] lane_base [NL];
  logic             mm_q;

  generate
    if (USE_TMR) begin : g_tmr
      logic disagree;

      for (genvar i = 0; i < NL; i++) begin : g_lane
        tmr_counter_lane #(.WIDTH(WIDTH), .MODE(MODE)) u_lane (
          .clk    (clk),
          .rst    (rst),
          .clr_i  (clr_i),
          .inc_i  (inc_i),
          .base_i (lane_base[i]),
          .q_o    (lane_q[i])
        );
      end

      if (VOTER == tmr_counter_pkg::VOTE_TRIPLE) begin : g_vote3
        logic [WIDTH-1:0] vote_y [NL];
        for (genvar i = 0; i < NL; i++) begin : g_v
          tmr_counter_vote #(.WIDTH(WIDTH)) u_vote (
            .a_i (lane_q[0]),
            .b_i (lane_q[1]),
            .c_i (lane_q[2]),
            .y_o (vote_y[i])
          );
          // Each copy is reloaded from its own vote output.
          assign lane_base[i] = vote_y[i];
        end
        assign count_o = vote_y[0];
      end else begin : g_vote1
        logic [WIDTH-1:0] vote_y;
        tmr_counter_vote #(.WIDTH(WIDTH)) u_vote (
          .a_i (lane_q[0]),
          .b_i (lane_q[1]),
          .c_i (lane_q[2]),
          .y_o (vote_y)
        );
        // Each copy steps from its own stored value.
        for (genvar i = 0; i < NL; i++) begin : g_b
          assign lane_base[i] = lane_q[i];
        end
        assign count_o = vote_y;
      end

      assign disagree = (lane_q[0] != lane_q[1]) | (lane_q[0] != lane_q[2]);

      always_ff @(posedge clk) begin
        if (rst) mm_q <= 1'b0;
        else     mm_q <= disagree;
      end

      // R9: the flag reports what the copies looked like at the previous edge.
      p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
        disagree |=> mismatch_o);
      p_flag_clr_r9: assert property (@(posedge clk) disable iff (rst)
        !disagree |=> !mismatch_o);

      if (VOTER == tmr_counter_pkg::VOTE_TRIPLE) begin : g_chk3
        // R7: whenever the flag is up, the repair has already happened.
        p_repaired_r7: assert property (@(posedge clk) disable iff (rst)
          mismatch_o |-> (lane_q[0] == lane_q[1]) && (lane_q[1] == lane_q[2]));
      end
    end else begin : g_plain
      tmr_counter_lane #(.WIDTH(WIDTH), .MODE(MODE)) u_lane (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_i),
        .inc_i  (inc_i),
        .base_i (lane_base[0]),
        .q_o    (lane_q[0])
      );
      assign lane_base[0] = lane_q[0];
      assign count_o      = lane_q[0];
      assign mm_q         = 1'b0;
    end
  endgenerate

  assign mismatch_o = mm_q;

  // R2: step by one below the limit, hold when idle.
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && count_o != MAXV) |=> count_o == $past(count_o) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !clr_i) |=> $stable(count_o));

  // R3: clear takes priority.
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> count_o == '0);

  generate
    if (MODE == tmr_counter_pkg::CNT_SAT) begin : g_chk_sat
      // R5: sticks at all ones.
      p_sat_r5: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i && count_o == MAXV) |=> count_o == MAXV);
    end else begin : g_chk_wrap
      // R4: rolls over to zero.
      p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !clr_i && count_o == MAXV) |=> count_o == '0);
    end
  endgenerate

endmodule

// File: tb/tmr_counter_tb.sv
`timescale 1ns/100ps
module tmr_counter_tb;
  import tmr_counter_pkg::*;

  localparam int W    = 4;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc_i = 1'b0;
  logic clr_i = 1'b0;

  logic [W-1:0] cnt_w [4];
  logic         mm_w  [4];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state, one entry per instance.
  int exp_cnt [4];
  bit exp_mm  [4];
  bit diff    [4];
  bit is_sat    [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
  bit is_triple [4] = '{1'b1, 1'b1, 1'b0, 1'b0};

  always #2.5 clk = ~clk;

  // 0: roll-over, three voters
  tmr_counter #(.WIDTH(W), .MODE(CNT_WRAP), .VOTER(VOTE_TRIPLE), .USE_TMR(1'b1)) u_dut (
    .clk(clk), .rst(rst), .inc_i(inc_i), .clr_i(clr_i),
    .count_o(cnt_w[0]), .mismatch_o(mm_w[0]));
  // 1: sticking, three voters
  tmr_counter #(.WIDTH(W), .MODE(CNT_SAT), .VOTER(VOTE_TRIPLE), .USE_TMR(1'b1)) u_dut_sat (
    .clk(clk), .rst(rst), .inc_i(inc_i), .clr_i(clr_i),
    .count_o(cnt_w[1]), .mismatch_o(mm_w[1]));
  // 2: roll-over, one voter
  tmr_counter #(.WIDTH(W), .MODE(CNT_WRAP), .VOTER(VOTE_SINGLE), .USE_TMR(1'b1)) u_dut_single (
    .clk(clk), .rst(rst), .inc_i(inc_i), .clr_i(clr_i),
    .count_o(cnt_w[2]), .mismatch_o(mm_w[2]));
  // 3: sticking, no redundancy
  tmr_counter #(.WIDTH(W), .MODE(CNT_SAT), .VOTER(VOTE_TRIPLE), .USE_TMR(1'b0)) u_dut_plain (
    .clk(clk), .rst(rst), .inc_i(inc_i), .clr_i(clr_i),
    .count_o(cnt_w[3]), .mismatch_o(mm_w[3]));

  task automatic model_edge();
    for (int i = 0; i < 4; i++) begin
      if (rst) begin
        exp_cnt[i] = 0;
        exp_mm[i]  = 1'b0;
        diff[i]    = 1'b0;
      end else begin
        exp_mm[i] = diff[i];
        if (is_triple[i] || clr_i) diff[i] = 1'b0;
        if (clr_i) exp_cnt[i] = 0;
        else if (inc_i) begin
          if (exp_cnt[i] == MAXC) exp_cnt[i] = is_sat[i] ? MAXC : 0;
          else exp_cnt[i] = exp_cnt[i] + 1;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < 4; i++) begin
      string ct;
      string mt;
      ct = (tag == "R4" && is_sat[i]) ? "R5" : tag;
      if (tag == "R1") mt = "R1";
      else if (i == 3) mt = "R10";
      else if (i == 2) mt = "R8";
      else mt = "R9";
      checks++;
      if (cnt_w[i] !== W'(exp_cnt[i])) begin
        errors++;
        $display("FAIL %s inst%0d count: actual %0d expected %0d", ct, i, cnt_w[i], exp_cnt[i]);
      end
      checks++;
      if (mm_w[i] !== exp_mm[i]) begin
        errors++;
        $display("FAIL %s inst%0d mismatch: actual %b expected %b", mt, i, mm_w[i], exp_mm[i]);
      end
    end
  endtask

  task automatic tick(input logic inc, input logic clr, input string tag);
    inc_i = inc;
    clr_i = clr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  // Corrupts one copy between edges (called at a falling edge).
  task automatic upset(input int idx);
    logic [W-1:0] v;
    v = W'(exp_cnt[idx]) ^ W'(4);
    case (idx)
      0: begin
        force u_dut.g_tmr.g_lane[1].u_lane.q = v;
        release u_dut.g_tmr.g_lane[1].u_lane.q;
      end
      1: begin
        force u_dut_sat.g_tmr.g_lane[2].u_lane.q = v;
        release u_dut_sat.g_tmr.g_lane[2].u_lane.q;
      end
      default: begin
        force u_dut_single.g_tmr.g_lane[0].u_lane.q = v;
        release u_dut_single.g_tmr.g_lane[0].u_lane.q;
      end
    endcase
    diff[idx] = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    rst = 1'b1;
    tick(1'b0, 1'b0, "R1");
    tick(1'b1, 1'b0, "R1");
    rst = 1'b0;
    // R2: counting and holding
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, "R2");
    tick(1'b0, 1'b0, "R2");
    tick(1'b0, 1'b0, "R2");
    // R3: clear with and without increment
    tick(1'b1, 1'b1, "R3");
    tick(1'b0, 1'b1, "R3");
    for (int k = 0; k < 3; k++) tick(1'b1, 1'b0, "R2");
    // R6: one copy corrupted in every redundant instance
    upset(0);
    upset(1);
    upset(2);
    tick(1'b1, 1'b0, "R6");
    // R7: repaired after one edge with three voters; R8: lasts with one voter
    tick(1'b1, 1'b0, "R7");
    tick(1'b0, 1'b0, "R8");
    // R4 / R5: run past the limit
    for (int k = 0; k < 14; k++) tick(1'b1, 1'b0, "R4");
    // R8: a clear removes the lasting disagreement
    tick(1'b0, 1'b1, "R8");
    tick(1'b0, 1'b0, "R8");
    for (int k = 0; k < 2; k++) tick(1'b1, 1'b0, "R2");
    // Corrupt an idle copy, then reset mid-run (R1)
    upset(2);
    upset(0);
    tick(1'b0, 1'b0, "R6");
    tick(1'b0, 1'b0, "R8");
    rst = 1'b1;
    tick(1'b1, 1'b0, "R1");
    rst = 1'b0;
    tick(1'b0, 1'b0, "R1");
    // R10 / R4 / R5: long run past the limit again
    for (int k = 0; k < 20; k++) tick(1'b1, 1'b0, "R4");
    tick(1'b1, 1'b1, "R3");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule